// File: doc/BRIEF.md
# Subroutine call and return unit

This block handles the three control-transfer instructions that give a 16-bit load/store processor its subroutine linkage. It takes the fetched instruction word, the already-incremented program counter and the value read from a register-file port whose index it selects. From these it produces the next program counter and a write request for the link register. There are two call forms. Both share opcode `0100` and are told apart by bit 11. One adds a signed 11-bit offset to the PC. The other jumps to the contents of a base register. The return is a jump through the fixed link register R7.

All outputs are combinational functions of the inputs. The link write is presented to the register file together with the retire strobe and is committed there on the clock edge when the instruction retires. An instruction that is not one of the three forms, or that has a reserved field that is not zero, is reported as not valid. It leaves the PC on its sequential path and writes nothing.

Top module: `subr_link_unit`

## Requirements
- R1: With bits [15:12] = `0100` and bit 11 = 1, the instruction is valid and `next_pc_o` equals `pc_inc_i` plus bits [10:0] sign-extended from bit 10, modulo 2^16.
- R2: With bits [15:12] = `0100`, bit 11 = 0, bits [10:9] = 0 and bits [5:0] = 0, the instruction is valid, `base_sel_o` equals bits [8:6], and `next_pc_o` equals `base_val_i`.
- R3: For either valid call form with `retire_i` high, `rf_we_o` is 1, `rf_waddr_o` is 7 and `rf_wdata_o` equals `pc_inc_i`.
- R4: The word `0xC1C0` (opcode `1100`, bits [8:6] = 7, all other bits 0) is a valid return: `base_sel_o` is 7, `next_pc_o` equals `base_val_i`, and `rf_we_o` is 0.
- R5: The offset reaches its extremes correctly: `0x400` adds -1024, `0x3FF` adds +1023, `0x7FF` adds -1, and a sum past `0xFFFF` wraps around.
- R6: A register call through R7 jumps to the R7 value presented on `base_val_i` (the value before the link write), while the link data is still `pc_inc_i`.
- R7: A call or return word with any reserved bit set is not valid (`valid_o` = 0), leaves `next_pc_o` equal to `pc_inc_i`, and gives `rf_we_o` = 0. A jump through any register other than R7 counts as reserved.
- R8: Any opcode other than `0100` and `1100` gives `valid_o` = 0, `next_pc_o` = `pc_inc_i` and `rf_we_o` = 0.
- R9: `rf_we_o` is 0 whenever `retire_i` is 0, even for a valid call.
- R10: While `rst` is high, `rf_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the register-file write |
| rst | input | 1 | Synchronous active-high reset, blocks the link write |
| instr_i | input | 16 | Fetched instruction word |
| pc_inc_i | input | 16 | Incremented program counter |
| base_val_i | input | 16 | Register-file read value for index `base_sel_o` |
| retire_i | input | 1 | Instruction retires at the coming edge |
| base_sel_o | output | 3 | Register index to read for the jump target |
| next_pc_o | output | 16 | Next program counter |
| valid_o | output | 1 | Instruction recognised as call or return |
| rf_we_o | output | 1 | Link register write enable |
| rf_waddr_o | output | 3 | Link register write index |
| rf_wdata_o | output | 16 | Link register write data |

## Verification
Several rules are checked by assertions on every cycle. Any link write must target R7 and carry the incremented PC. Nothing may be written without retire or during reset. A word that is not valid must leave the PC sequential. A valid return, and a valid register call, must take their target from the base-register read. The arithmetic of the PC-relative target can only be shown by the bench's scenarios. This covers sign extension at both ends of the offset range and wrap past the top of the address space. The bench scenarios also cover the R7-based call, where the jump target and the link data differ, and the exact reserved-field patterns that must be rejected.

// File: rtl/subr_pkg.sv
package subr_pkg;

    localparam int XLEN      = 16;
    localparam int OFF_W     = 11;
    localparam int IDX_W     = 3;
    localparam int OPC_W     = 4;
    localparam logic [IDX_W-1:0] LINK_IDX = 3'd7;

    localparam logic [OPC_W-1:0] OPC_CALL = 4'b0100;
    localparam logic [OPC_W-1:0] OPC_JUMP = 4'b1100;

    typedef enum logic [1:0] {
        XFER_NONE   = 2'd0,
        XFER_CALL_R = 2'd1,
        XFER_CALL_B = 2'd2,
        XFER_RET    = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        xfer_kind_e            kind;
        logic                  ok;
        logic [IDX_W-1:0]      base;
        logic [XLEN-1:0]       offset;
    } xfer_dec_t;

    function automatic logic [XLEN-1:0] sext_off(input logic [OFF_W-1:0] f);
        return {{(XLEN-OFF_W){f[OFF_W-1]}}, f};
    endfunction

    function automatic logic is_link_kind(input xfer_kind_e k);
        return (k == XFER_CALL_R) || (k == XFER_CALL_B);
    endfunction

endpackage

// File: rtl/subr_decode.sv
module subr_decode
    import subr_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output xfer_dec_t       dec
);
    logic [OPC_W-1:0] opc;
    logic             mode;
    logic [IDX_W-1:0] rb;
    logic [1:0]       mid;
    logic [5:0]       low;

    assign opc  = instr[15:12];
    assign mode = instr[11];
    assign mid  = instr[10:9];
    assign rb   = instr[8:6];
    assign low  = instr[5:0];

    always_comb begin
        dec        = '0;
        dec.kind   = XFER_NONE;
        dec.offset = sext_off(instr[OFF_W-1:0]);
        dec.base   = rb;
        unique case (opc)
            OPC_CALL: begin
                if (mode) begin
                    dec.kind = XFER_CALL_R;
                    dec.ok   = 1'b1;
                end else begin
                    dec.kind = XFER_CALL_B;
                    dec.ok   = (mid == 2'b00) && (low == 6'd0);
                end
            end
            OPC_JUMP: begin
                dec.kind = XFER_RET;
                dec.base = LINK_IDX;
                dec.ok   = (instr[11:9] == 3'b000) && (rb == LINK_IDX) && (low == 6'd0);
            end
            default: begin
                dec.kind = XFER_NONE;
                dec.ok   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/subr_target.sv
module subr_target
    import subr_pkg::*;
(
    input  xfer_dec_t       dec,
    input  logic [XLEN-1:0] pc_inc,
    input  logic [XLEN-1:0] base_val,
    output logic [XLEN-1:0] next_pc
);
    logic [XLEN-1:0] rel_tgt;

    assign rel_tgt = pc_inc + dec.offset;

    always_comb begin
        next_pc = pc_inc;
        if (dec.ok) begin
            unique case (dec.kind)
                XFER_CALL_R: next_pc = rel_tgt;
                XFER_CALL_B: next_pc = base_val;
                XFER_RET:    next_pc = base_val;
                default:     next_pc = pc_inc;
            endcase
        end
    end
endmodule

// File: rtl/subr_link.sv
module subr_link
    import subr_pkg::*;
(
    input  logic            rst,
    input  logic            retire,
    input  xfer_dec_t       dec,
    input  logic [XLEN-1:0] pc_inc,
    output logic            we,
    output logic [IDX_W-1:0] waddr,
    output logic [XLEN-1:0] wdata
);
    assign we    = !rst && retire && dec.ok && is_link_kind(dec.kind);
    assign waddr = LINK_IDX;
    assign wdata = pc_inc;
endmodule

// File: rtl/subr_link_unit.sv
module subr_link_unit
    import subr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [XLEN-1:0]  instr_i,
    input  logic [XLEN-1:0]  pc_inc_i,
    input  logic [XLEN-1:0]  base_val_i,
    input  logic             retire_i,
    output logic [IDX_W-1:0] base_sel_o,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             valid_o,
    output logic             rf_we_o,
    output logic [IDX_W-1:0] rf_waddr_o,
    output logic [XLEN-1:0]  rf_wdata_o
);
    xfer_dec_t dec;

    subr_decode u_dec (.instr(instr_i), .dec(dec));

    subr_target u_tgt (
        .dec(dec), .pc_inc(pc_inc_i), .base_val(base_val_i), .next_pc(next_pc_o)
    );

    subr_link u_lnk (
        .rst(rst), .retire(retire_i), .dec(dec), .pc_inc(pc_inc_i),
        .we(rf_we_o), .waddr(rf_waddr_o), .wdata(rf_wdata_o)
    );

    assign base_sel_o = dec.base;
    assign valid_o    = dec.ok;

    assert_link_write_R3: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> (rf_waddr_o == 3'd7) && (rf_wdata_o == pc_inc_i));

    assert_no_write_unretired_R9: assert property (@(posedge clk) disable iff (rst)
        !retire_i |-> !rf_we_o);

    assert_invalid_holds_pc_R7: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (next_pc_o == pc_inc_i) && !rf_we_o);

    assert_return_target_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_o && instr_i == 16'hC1C0) |-> (next_pc_o == base_val_i) && (base_sel_o == 3'd7) && !rf_we_o);

    assert_reg_call_target_R2: assert property (@(posedge clk) disable iff (rst)
        (valid_o && instr_i[15:11] == 5'b01000) |-> (next_pc_o == base_val_i) && (base_sel_o == instr_i[8:6]));

    assert_reset_blocks_write_R10: assert property (@(posedge clk)
        rst |-> !rf_we_o);
endmodule

// File: tb/sim_subr_link_unit.sv
module sim_subr_link_unit;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        logic        valid;
        logic [15:0] npc;
        logic        we;
        logic [15:0] wdata;
        logic        chk_sel;
        logic [2:0]  sel;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr_i = 16'h0000;
    logic [15:0] pc_inc_i = 16'h0000;
    logic [15:0] base_val_i = 16'h0000;
    logic        retire_i = 1'b0;
    logic [2:0]  base_sel_o;
    logic [15:0] next_pc_o;
    logic        valid_o;
    logic        rf_we_o;
    logic [2:0]  rf_waddr_o;
    logic [15:0] rf_wdata_o;

    int   n_vec = 0;
    int   n_bad = 0;
    exp_t sb[$];
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    subr_link_unit u0 (
        .clk(clk), .rst(rst), .instr_i(instr_i), .pc_inc_i(pc_inc_i),
        .base_val_i(base_val_i), .retire_i(retire_i), .base_sel_o(base_sel_o),
        .next_pc_o(next_pc_o), .valid_o(valid_o), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
    );

    function automatic logic [15:0] sx(input logic [10:0] f);
        return {{5{f[10]}}, f};
    endfunction

    task automatic put(input logic [15:0] ins, input logic [15:0] pc, input logic [15:0] bv,
                       input logic ret, input exp_t e);
        @(posedge clk);
        #1;
        instr_i = ins; pc_inc_i = pc; base_val_i = bv; retire_i = ret;
        sb.push_back(e);
    endtask

    function automatic exp_t mk(input logic v, input logic [15:0] npc, input logic we,
                                input logic [15:0] wd, input logic cs, input logic [2:0] sel,
                                input string req);
        exp_t e;
        e.valid = v; e.npc = npc; e.we = we; e.wdata = wd;
        e.chk_sel = cs; e.sel = sel; e.req = req;
        return e;
    endfunction

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb.pop_front();
            n_vec++;
            bad = (valid_o !== e.valid) || (next_pc_o !== e.npc) || (rf_we_o !== e.we);
            if (e.we && ((rf_waddr_o !== 3'd7) || (rf_wdata_o !== e.wdata))) bad = 1'b1;
            if (e.chk_sel && (base_sel_o !== e.sel)) bad = 1'b1;
            if (bad) begin
                n_bad++;
                $display("FAIL %s: got valid=%b npc=%h we=%b waddr=%0d wdata=%h sel=%0d exp valid=%b npc=%h we=%b waddr=7 wdata=%h sel=%0d",
                         e.req, valid_o, next_pc_o, rf_we_o, rf_waddr_o, rf_wdata_o, base_sel_o,
                         e.valid, e.npc, e.we, e.wdata, e.sel);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: link write blocked during reset even for a retiring call
        put(16'h4805, 16'h3000, 16'h0000, 1'b1, mk(1, 16'h3005, 0, 16'h3000, 0, 0, "R10"));
        @(posedge clk); #1; rst = 1'b0;
        // R1 / R3: PC-relative call, small positive offset
        put(16'h4805, 16'h3000, 16'h1111, 1'b1, mk(1, 16'h3005, 1, 16'h3000, 0, 0, "R1"));
        // R5: offset -1
        put(16'h4FFF, 16'h3000, 16'h0000, 1'b1, mk(1, 16'h3000 + sx(11'h7FF), 1, 16'h3000, 0, 0, "R5"));
        // R5: most negative offset
        put(16'h4C00, 16'h3000, 16'h0000, 1'b1, mk(1, 16'h3000 - 16'd1024, 1, 16'h3000, 0, 0, "R5"));
        // R5: most positive offset
        put(16'h4BFF, 16'h3000, 16'h0000, 1'b1, mk(1, 16'h3000 + 16'd1023, 1, 16'h3000, 0, 0, "R5"));
        // R5: wrap past top
        put(16'h4820, 16'hFFF0, 16'h0000, 1'b1, mk(1, 16'h0010, 1, 16'hFFF0, 0, 0, "R5"));
        // R2 / R3: register call through R3
        put(16'h40C0, 16'h2222, 16'h8ABC, 1'b1, mk(1, 16'h8ABC, 1, 16'h2222, 1, 3'd3, "R2"));
        // R6: register call through R7
        put(16'h41C0, 16'h4444, 16'h5A5A, 1'b1, mk(1, 16'h5A5A, 1, 16'h4444, 1, 3'd7, "R6"));
        // R4: return
        put(16'hC1C0, 16'h6000, 16'h3001, 1'b1, mk(1, 16'h3001, 0, 16'h0, 1, 3'd7, "R4"));
        // R9: valid call not retiring
        put(16'h4805, 16'h3000, 16'h0000, 1'b0, mk(1, 16'h3005, 0, 16'h0, 0, 0, "R9"));
        // R7: register call with reserved bit 9 set
        put(16'h42C0, 16'h1000, 16'h7777, 1'b1, mk(0, 16'h1000, 0, 16'h0, 0, 0, "R7"));
        // R7: register call with reserved bit 0 set
        put(16'h40C1, 16'h1000, 16'h7777, 1'b1, mk(0, 16'h1000, 0, 16'h0, 0, 0, "R7"));
        // R7: jump through R3 is not a return
        put(16'hC0C0, 16'h1000, 16'h7777, 1'b1, mk(0, 16'h1000, 0, 16'h0, 0, 0, "R7"));
        // R7: return word with bit 11 set
        put(16'hC9C0, 16'h1000, 16'h7777, 1'b1, mk(0, 16'h1000, 0, 16'h0, 0, 0, "R7"));
        // R8: unrelated opcodes
        put(16'h1234, 16'h0ABC, 16'h7777, 1'b1, mk(0, 16'h0ABC, 0, 16'h0, 0, 0, "R8"));
        put(16'hF025, 16'h0ABD, 16'h7777, 1'b1, mk(0, 16'h0ABD, 0, 16'h0, 0, 0, "R8"));
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule